// File: doc/BRIEF.md
# Buffered Burst I2C Master

This block is a byte-wide register window in front of a bit-level I2C master. Software writes a slave address byte (seven address bits plus a direction bit), a byte count and up to sixteen data bytes, then writes the control register. A single start command runs the whole burst: a START condition, the address byte, then count+1 data bytes. On a write burst the bytes go out from the buffer. On a read burst the bytes land in the buffer.

The burst leaves the bus held (SCL low) so that software can inspect the result before it releases the bus. A second control command issues the STOP and also clears the error flag. Status reports busy, error and complete. A write to the reset register, which shares its offset with status, can also clear the error flag.

SCL and SDA are open-drain. Each has an active-high pull-low enable and a sampled line input. SCL runs from a divider of the system clock, and the master waits while a slave holds SCL low.

Top module: `i2c_burst_master`

## Requirements
- R1: After reset, every register in the window reads 0x00 (count 0x00, status 0x02, address 0x03, buffer 0x04..0x13), and both line enables are low (bus released).
- R2: The count register at 0x00 keeps only bits 3:0, so writing 0xFF reads back 0x0F. A burst moves exactly count+1 data bytes.
- R3: The control register at 0x01 acts only when bit 0 (enable) is set. Enable=1 with bit 2 (start) set launches a burst, and enable=1 with start=0 requests a STOP. A write with enable=0 causes no bus activity and changes no status.
- R4: With address register (0x03) bit 0 = 0, a burst sends the address byte, then buffer bytes 0x04 upward, MSB first. When every byte is ACKed, status (0x02) reads exactly 0x08 (bit 3 complete).
- R5: With address bit 0 = 1, a burst reads count+1 bytes into buffer offsets 0x04 upward. The master ACKs every byte except the last, which it NACKs. Success also leaves status at exactly 0x08.
- R6: A NACK on the address byte sets status bit 2 (error) and sends no data bytes.
- R7: A NACK on a written data byte sets error, stops the burst after that byte, and leaves complete clear.
- R8: Writing offset 0x02 with bit 2 = 0 clears error. Writing it with bit 2 = 1 leaves error unchanged.
- R9: A STOP request while idle drives a STOP condition, leaves both lines released, and clears error.
- R10: Status bit 0 reads 1 while a burst or STOP is in progress. A start command written during that time is ignored, so no second START condition appears.
- R11: After a burst ends, with success or with error, SCL stays pulled low until a STOP is requested.
- R12: Launching a burst clears the complete bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The assertions assume that software leaves the count, address and buffer registers alone while status bit 0 is set. They also assume that the slave drives SDA only while SCL is low, so that START and STOP conditions come only from the master. The bench polls busy before it touches those registers. Its behavioural slave changes SDA only on observed SCL falling edges and counts every START and STOP it detects. The one deliberate write during a busy burst is a control start command, which the block is required to ignore.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [1:0] {
    PCMD_START   = 2'd0,
    PCMD_BYTE_WR = 2'd1,
    PCMD_BYTE_RD = 2'd2,
    PCMD_STOP    = 2'd3
  } pcmd_e;

  localparam int REG_COUNT = 0;
  localparam int REG_CTRL  = 1;
  localparam int REG_STAT  = 2;
  localparam int REG_SADDR = 3;
  localparam int BUF_BASE  = 4;

  // control decode: bit0 enable, bit2 start
  function automatic logic ctl_launch(input logic [7:0] d);
    return d[0] & d[2];
  endfunction

  function automatic logic ctl_halt(input logic [7:0] d);
    return d[0] & ~d[2];
  endfunction

  // reset register: bit2 low requests an error clear
  function automatic logic err_clear_req(input logic [7:0] d);
    return ~d[2];
  endfunction

  // status byte layout: bit3 complete, bit2 error, bit0 busy
  function automatic logic [7:0] status_byte(input logic comp, input logic err,
                                             input logic bsy);
    return {4'b0000, comp, err, 1'b0, bsy};
  endfunction
endpackage

// File: rtl/i2cb_phy.sv
module i2cb_phy
  import i2cb_pkg::*;
#(
  parameter int QTR = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  pcmd_e      kind,
  input  logic [7:0] tx_byte,
  input  logic       rd_ack,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       nack,
  output logic       active,
  output logic       held,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic          ackq;
  pcmd_e         kd;

  logic tick, last_bit, is_byte, stretch_wait, bit_low;
  assign tick         = active && (cnt == CW'(QTR - 1));
  assign last_bit     = (bitn == 4'd8);
  assign is_byte      = (kd == PCMD_BYTE_WR) || (kd == PCMD_BYTE_RD);
  assign stretch_wait = is_byte && (ph == 2'd2) && !scl_in;
  assign bit_low      = (kd == PCMD_BYTE_WR) ? (!last_bit && !sh[7]) : (last_bit && ackq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; ph <= '0; bitn <= '0; sh <= '0; ackq <= 1'b0; kd <= PCMD_START;
      done <= 1'b0; rx_byte <= '0; nack <= 1'b0; active <= 1'b0; held <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        if (kind == PCMD_STOP && !held) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1; kd <= kind; ph <= '0; bitn <= '0; cnt <= '0;
          sh <= tx_byte; ackq <= rd_ack; nack <= 1'b0;
        end
      end else if (active) begin
        if (!tick) begin
          cnt <= cnt + 1'b1;
        end else if (!stretch_wait) begin
          cnt <= '0;
          ph  <= ph + 2'd1;
          case (kd)
            PCMD_START: begin
              case (ph)
                2'd0: sda_oe <= 1'b0;
                2'd1: scl_oe <= 1'b0;
                2'd2: sda_oe <= 1'b1;
                default: begin scl_oe <= 1'b1; held <= 1'b1; active <= 1'b0; done <= 1'b1; end
              endcase
            end
            PCMD_STOP: begin
              case (ph)
                2'd0: sda_oe <= 1'b1;
                2'd1: scl_oe <= 1'b0;
                2'd2: sda_oe <= 1'b0;
                default: begin held <= 1'b0; active <= 1'b0; done <= 1'b1; end
              endcase
            end
            default: begin
              case (ph)
                2'd0: sda_oe <= bit_low;
                2'd1: scl_oe <= 1'b0;
                2'd2: begin
                  if (last_bit) nack <= sda_in;
                  else if (kd == PCMD_BYTE_RD) rx_byte <= {rx_byte[6:0], sda_in};
                end
                default: begin
                  scl_oe <= 1'b1;
                  if (last_bit) begin
                    active <= 1'b0; done <= 1'b1;
                  end else begin
                    bitn <= bitn + 4'd1;
                    sh   <= {sh[6:0], 1'b0};
                  end
                end
              endcase
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            halt,
  input  logic            rd_dir,
  input  logic [IDXW-1:0] last_idx,
  input  logic            phy_done,
  input  logic            phy_nack,
  output logic            phy_go,
  output pcmd_e           phy_kind,
  output logic            sel_addr,
  output logic            want_ack,
  output logic [IDXW-1:0] idx,
  output logic            store,
  output logic            ok,
  output logic            fail,
  output logic            busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_ST_GO, S_ST_W, S_AD_GO, S_AD_W, S_DT_GO, S_DT_W, S_SP_GO, S_SP_W
  } sstate_e;

  sstate_e         st;
  logic            dir_q;
  logic [IDXW-1:0] last_q;
  logic            wr_nack, at_last;

  assign busy     = (st != S_IDLE);
  assign phy_go   = (st == S_ST_GO) || (st == S_AD_GO) || (st == S_DT_GO) || (st == S_SP_GO);
  assign sel_addr = (st == S_AD_GO);
  assign want_ack = (idx != last_q);
  assign at_last  = (idx == last_q);
  assign wr_nack  = !dir_q && phy_nack;
  assign store    = (st == S_DT_W) && phy_done && dir_q;
  assign ok       = (st == S_DT_W) && phy_done && !wr_nack && at_last;
  assign fail     = phy_done && (((st == S_DT_W) && wr_nack) || ((st == S_AD_W) && phy_nack));

  always_comb begin
    case (st)
      S_ST_GO: phy_kind = PCMD_START;
      S_SP_GO: phy_kind = PCMD_STOP;
      S_DT_GO: phy_kind = dir_q ? PCMD_BYTE_RD : PCMD_BYTE_WR;
      default: phy_kind = PCMD_BYTE_WR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dir_q <= 1'b0; last_q <= '0; idx <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (launch) begin
            dir_q <= rd_dir; last_q <= last_idx; idx <= '0; st <= S_ST_GO;
          end else if (halt) begin
            st <= S_SP_GO;
          end
        end
        S_ST_GO: st <= S_ST_W;
        S_ST_W:  if (phy_done) st <= S_AD_GO;
        S_AD_GO: st <= S_AD_W;
        S_AD_W:  if (phy_done) st <= phy_nack ? S_IDLE : S_DT_GO;
        S_DT_GO: st <= S_DT_W;
        S_DT_W: begin
          if (phy_done) begin
            if (wr_nack || at_last) st <= S_IDLE;
            else begin idx <= idx + 1'b1; st <= S_DT_GO; end
          end
        end
        S_SP_GO: st <= S_SP_W;
        S_SP_W:  if (phy_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
  import i2cb_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCL_HZ    = 100_000,
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = $clog2(BUF_BASE + BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam int IDXW = $clog2(BUF_BYTES);
  localparam int QTR  = (CLK_HZ / (4 * SCL_HZ) > 0) ? CLK_HZ / (4 * SCL_HZ) : 1;

  logic [IDXW-1:0] cnt_q;
  logic [7:0]      saddr_q;
  logic [7:0]      buf_q [BUF_BYTES];
  logic            st_complete, st_error;

  // named internal events
  logic launch, stop_req, rst_clr, seq_busy, seq_ok, seq_fail, seq_store;
  logic phy_go, phy_done, phy_nack, phy_active, bus_held, sel_addr, want_ack;
  logic [IDXW-1:0] seq_idx;
  logic [7:0]      rx_byte, tx_byte;
  pcmd_e           phy_kind;

  assign launch   = bus_wr && (bus_addr == ADDR_W'(REG_CTRL)) && ctl_launch(bus_wdata);
  assign stop_req = bus_wr && (bus_addr == ADDR_W'(REG_CTRL)) && ctl_halt(bus_wdata);
  assign rst_clr  = bus_wr && (bus_addr == ADDR_W'(REG_STAT)) && err_clear_req(bus_wdata);
  assign tx_byte  = sel_addr ? saddr_q : buf_q[seq_idx];

  i2cb_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .halt(stop_req),
    .rd_dir(saddr_q[0]), .last_idx(cnt_q), .phy_done(phy_done), .phy_nack(phy_nack),
    .phy_go(phy_go), .phy_kind(phy_kind), .sel_addr(sel_addr), .want_ack(want_ack),
    .idx(seq_idx), .store(seq_store), .ok(seq_ok), .fail(seq_fail), .busy(seq_busy)
  );

  i2cb_phy #(.QTR(QTR)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(phy_go), .kind(phy_kind), .tx_byte(tx_byte),
    .rd_ack(want_ack), .done(phy_done), .rx_byte(rx_byte), .nack(phy_nack),
    .active(phy_active), .held(bus_held), .scl_oe(scl_oe), .scl_in(scl_in),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; saddr_q <= '0; st_complete <= 1'b0; st_error <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(REG_COUNT)) cnt_q <= bus_wdata[IDXW-1:0];
      if (bus_wr && bus_addr == ADDR_W'(REG_SADDR)) saddr_q <= bus_wdata;
      if (seq_ok) st_complete <= 1'b1;
      else if (launch && !seq_busy) st_complete <= 1'b0;
      if (seq_fail) st_error <= 1'b1;
      else if (seq_ok || ((stop_req || rst_clr) && !seq_busy)) st_error <= 1'b0;
    end
  end

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) buf_q[i] <= '0;
      else if (seq_store && seq_idx == IDXW'(i)) buf_q[i] <= rx_byte;
      else if (bus_wr && bus_addr == ADDR_W'(BUF_BASE + i)) buf_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(REG_COUNT)) bus_rdata = 8'(cnt_q);
    else if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata = status_byte(st_complete, st_error, seq_busy);
    else if (bus_addr == ADDR_W'(REG_SADDR)) bus_rdata = saddr_q;
    else begin
      for (int i = 0; i < BUF_BYTES; i++)
        if (bus_addr == ADDR_W'(BUF_BASE + i)) bus_rdata = buf_q[i];
    end
  end
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic st_complete,
  input logic st_error,
  input logic phy_go,
  input logic phy_active,
  input logic bus_held,
  input logic scl_oe,
  input logic sda_oe,
  input logic stop_req,
  input logic rst_clr
);
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_complete) |-> (!st_error && !busy)); // R4

  AST_FAIL_NO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_error) |-> !st_complete); // R7

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_go |-> !phy_active); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_held) |-> (!scl_oe && !sda_oe)); // R9

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_held && !phy_active) |-> scl_oe); // R11

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !busy) |=> !st_error); // R9

  AST_RSTREG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_clr && !busy) |=> !st_error); // R8
endmodule

bind i2c_burst_master i2cb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .st_complete(st_complete),
  .st_error(st_error), .phy_go(phy_go), .phy_active(phy_active),
  .bus_held(bus_held), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .stop_req(stop_req), .rst_clr(rst_clr)
);

// File: tb/i2c_burst_master_test.sv
`timescale 1ns/1ps
module i2c_burst_master_test;
  localparam logic [6:0] SLV = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic scl_oe, sda_oe;
  bit   slv_oe = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_oe);

  always #5 clk = !clk;

  i2c_burst_master #(.CLK_HZ(100_000_000), .SCL_HZ(12_500_000)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe),
    .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] rd_pat(input int i);
    return 8'(8'h3C ^ (i * 37));
  endfunction
  function automatic logic [7:0] wr_pat(input int i, input int n);
    return 8'(i * 17 + n * 3 + 1);
  endfunction

  // ---------------- behavioural slave ----------------
  bit addr_nack = 1'b0;
  int nack_at = -1;
  int start_cnt = 0, stop_cnt = 0, wr_got = 0, rd_served = 0;
  logic [7:0] mem_w [0:16];
  bit mack_hist [0:16];
  bit pscl = 1'b1, psda = 1'b1, sack = 1'b0, rwb = 1'b0, mack = 1'b0;
  int mode = 0, bitc = 0, widx = 0, ridx = 0;
  logic [7:0] sh = '0, rsh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && psda && !sda_line) begin
        start_cnt++; mode = 1; bitc = 0; slv_oe = 1'b0; wr_got = 0; rd_served = 0;
      end else if (scl_line && !psda && sda_line) begin
        stop_cnt++; mode = 0; slv_oe = 1'b0;
      end else if (!pscl && scl_line) begin
        if ((mode == 1 || mode == 2) && bitc < 8) begin sh = {sh[6:0], sda_line}; bitc++; end
        else if (mode == 3 && bitc == 9) mack = !sda_line;
      end else if (pscl && !scl_line) begin
        case (mode)
          1: if (bitc == 8) begin
               sack = (sh[7:1] == SLV) && !addr_nack; rwb = sh[0]; slv_oe = sack; bitc = 9;
             end else if (bitc == 9) begin
               slv_oe = 1'b0; bitc = 0;
               if (!sack) mode = 0;
               else if (rwb) begin
                 mode = 3; ridx = 0; rsh = rd_pat(0); slv_oe = !rsh[7];
                 rsh = {rsh[6:0], 1'b0}; bitc = 1;
               end else begin mode = 2; widx = 0; end
             end
          2: if (bitc == 8) begin
               mem_w[widx] = sh; sack = (widx != nack_at); slv_oe = sack; bitc = 9;
             end else if (bitc == 9) begin
               slv_oe = 1'b0; bitc = 0; widx++; wr_got = widx;
               if (!sack) mode = 0;
             end
          3: if (bitc < 8) begin
               slv_oe = !rsh[7]; rsh = {rsh[6:0], 1'b0}; bitc++;
             end else if (bitc == 8) begin
               slv_oe = 1'b0; bitc = 9;
             end else begin
               mack_hist[ridx] = mack; ridx++; rd_served = ridx;
               if (mack) begin
                 rsh = rd_pat(ridx); slv_oe = !rsh[7]; rsh = {rsh[6:0], 1'b0}; bitc = 1;
               end else mode = 4;
             end
          default: ;
        endcase
      end
      pscl = scl_line; psda = sda_line;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); bus_addr = 5'(a); #1 v = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int n;
    n = 0;
    rd(2, s);
    while (s[0] && n < 5000) begin rd(2, s); n++; end
    check(!s[0], req, int'(s), 0);
  endtask

  task automatic do_stop();
    int sc;
    sc = stop_cnt;
    wr(1, 8'h01);
    wait_idle("R9");
    repeat (4) @(negedge clk);
    check(!scl_oe && !sda_oe, "R9", {scl_oe, sda_oe}, 0);
    check(stop_cnt == sc + 1, "R9", stop_cnt - sc, 1);
  endtask

  // ---------------- main sequence ----------------
  initial begin : main
    logic [7:0] v;
    int sc;
    bit good;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 20; a++) begin
      rd(a, v); check(v == 8'h00, "R1", v, 0);
    end
    check(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);

    // R2 count masking
    wr(0, 8'hFF); rd(0, v); check(v == 8'h0F, "R2", v, 8'h0F);

    // R3 enable low does nothing
    wr(3, {SLV, 1'b0});
    sc = start_cnt;
    wr(1, 8'h04);
    repeat (60) @(negedge clk);
    rd(2, v); check(v == 8'h00, "R3", v, 0);
    check(start_cnt == sc && !scl_oe, "R3", start_cnt - sc, 0);

    // R4 / R2 / R10 / R11 write sweep
    for (int n = 0; n < 16; n++) begin
      for (int i = 0; i < 16; i++) wr(4 + i, wr_pat(i, n));
      wr(0, n);
      wr(3, {SLV, 1'b0});
      sc = start_cnt;
      wr(1, 8'h05);
      rd(2, v); check(v[0] == 1'b1, "R10", v, 1);
      if (n == 3) wr(1, 8'h05);
      wait_idle("R10");
      rd(2, v); check(v == 8'h08, "R4", v, 8'h08);
      check(scl_oe == 1'b1, "R11", scl_oe, 1);
      check(wr_got == n + 1, "R2", wr_got, n + 1);
      check(start_cnt == sc + 1, "R10", start_cnt - sc, 1);
      good = 1'b1;
      for (int i = 0; i <= n; i++) if (mem_w[i] != wr_pat(i, n)) good = 1'b0;
      check(good, "R4", n, n);
      do_stop();
    end

    // R5 read sweep
    for (int n = 0; n < 16; n++) begin
      for (int i = 0; i < 16; i++) wr(4 + i, 0);
      wr(0, n);
      wr(3, {SLV, 1'b1});
      wr(1, 8'h05);
      wait_idle("R5");
      rd(2, v); check(v == 8'h08, "R5", v, 8'h08);
      check(rd_served == n + 1, "R5", rd_served, n + 1);
      good = 1'b1;
      for (int i = 0; i <= n; i++) begin
        rd(4 + i, v);
        if (v != rd_pat(i)) good = 1'b0;
        if (mack_hist[i] != (i < n)) good = 1'b0;
      end
      check(good, "R5", n, n);
      do_stop();
    end

    // R6 address NACK, R8 reset register
    addr_nack = 1'b1;
    wr(0, 3); wr(3, {SLV, 1'b0}); wr(1, 8'h05);
    wait_idle("R6");
    rd(2, v); check(v == 8'h04, "R6", v, 8'h04);
    check(wr_got == 0, "R6", wr_got, 0);
    check(scl_oe == 1'b1, "R11", scl_oe, 1);
    wr(2, 8'h04); rd(2, v); check(v == 8'h04, "R8", v, 8'h04);
    wr(2, 8'h00); rd(2, v); check(v == 8'h00, "R8", v, 0);
    do_stop();
    addr_nack = 1'b0;

    // success then data NACK: R12, R7, then R9 clears error
    wr(0, 0); wr(1, 8'h05); wait_idle("R4");
    rd(2, v); check(v == 8'h08, "R4", v, 8'h08);
    do_stop();
    nack_at = 2;
    wr(0, 5); wr(1, 8'h05);
    rd(2, v); check(v[3] == 1'b0, "R12", v, 1);
    wait_idle("R7");
    rd(2, v); check(v == 8'h04, "R7", v, 8'h04);
    check(wr_got == 3, "R7", wr_got, 3);
    do_stop();
    rd(2, v); check(v == 8'h00, "R9", v, 0);
    nack_at = -1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule